// File: doc/BRIEF.md
# I2C Target with 7-bit and 10-bit Addressing

This block is an I2C target engine that runs from a fast system clock and oversamples the open-drain SCL and SDA lines through two-flop synchronisers. It recognises START, repeated START and STOP conditions. It matches its own address in either 7-bit or 10-bit form and then exchanges one to four data bytes per frame with the controller. Received bytes are packed into one 32-bit word, and transmitted bytes are taken from one 32-bit word.

The surrounding logic supplies the own address, the addressing mode, the index of the last byte in a frame, the policy for the final ACK, the transmit word and an optional clock-stretch setting. Back from the block come the received word, level flags for "addressed" and "read in progress", a sticky STOP flag and a one-cycle pulse at the end of each frame. The outputs `scl_oe` and `sda_oe` pull the bus lines low when they are high. The pad keeps the lines released otherwise.

Top module: `i2c_tgt10`

## Requirements
- R1: After reset `scl_oe`, `sda_oe`, `addressed`, `rd_mode`, `frame_done` and `stop_seen` are 0, and `rx_word` is 0.
- R2: START and repeated START are SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both judged on the synchronised lines. A STOP sets `stop_seen` and returns the block to idle from any state, so that later bits are ignored until a START. A START clears `stop_seen`.
- R3: In 7-bit mode (`addr_10b`=0) the first byte after a START matches when its bits 7:1 equal `own_addr[6:0]`. Bit 0 is R/W, where 1 means read. On a match the target pulls SDA low in the ninth clock (ACK). On a mismatch it leaves SDA high (NACK) and ignores the rest of the frame.
- R4: In 10-bit mode the first byte must be 1 1 1 1 0 `own_addr[9]` `own_addr[8]` 0 and the second byte must equal `own_addr[7:0]`. Each matching byte is ACKed. A mismatch in either byte gives NACK and the frame is ignored.
- R5: In 10-bit mode a first byte 1 1 1 1 0 `own_addr[9:8]` 1 is ACKed and starts a transmit only if a full 10-bit write match has occurred since the last STOP. Without such a match it is NACKed.
- R6: A write address match clears `rx_word`. Received byte k (k = 0 for the first data byte) is shifted in MSB first and stored in `rx_word[8k+7:8k]` for k up to `last_idx`.
- R7: Every received byte is ACKed, except that the byte with index `last_idx` is NACKed when `nack_last`=1. Bytes after that index are NACKed and leave `rx_word` unchanged.
- R8: In a read, byte k is taken from `tx_word[8k+7:8k]` and sent MSB first. The transfer ends after a controller NACK or after byte `last_idx`. After the end SDA stays released, so further bytes read 0xFF.
- R9: The target changes its SDA drive only while SCL is low.
- R10: `frame_done` pulses for one cycle at the SCL fall that closes the ACK slot of the frame's final byte: byte `last_idx`, or a byte the controller NACKs in a read.
- R11: Data bits of a frame are numbered from 1, across bytes, with the address and ACK bits left out. When `stretch_len` is non-zero, the target holds SCL low for `stretch_len` clocks after the SCL fall that ends data bit `stretch_at`. It holds SCL at no other time.
- R12: `addressed` rises when the target finishes acknowledging its address, and `rd_mode` rises with it for a read. Both clear at the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| own_addr | input | 10 | Own address, bits 6:0 used in 7-bit mode |
| addr_10b | input | 1 | 1 selects 10-bit addressing |
| last_idx | input | 2 | Index of the last data byte of a frame (0 to 3) |
| nack_last | input | 1 | NACK the last received byte |
| tx_word | input | 32 | Bytes to transmit, byte 0 in bits 7:0 |
| stretch_at | input | 6 | Data bit number after which SCL is held |
| stretch_len | input | STRW | Stretch duration in clocks, 0 disables |
| rx_word | output | 32 | Received bytes, byte 0 in bits 7:0 |
| rd_mode | output | 1 | Target is transmitting in this frame |
| addressed | output | 1 | Target has been addressed in this frame |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |
| stop_seen | output | 1 | Set by STOP, cleared by START |

## Verification
A bit counter that is off by one shows up on the bus within the same byte. The ACK lands in a data slot, or the returned byte comes out shifted, and the bench compares every ACK bit and every read byte against its own model. A lost 10-bit match state shows up as a NACK on the repeated-START read header. A stale phase after STOP shows up as an ACK on a frame that should be ignored. A wrong stretch position moves the observed SCL hold to another bit, which the bench times with the clock. The packed receive word is compared once per frame at its STOP.

// File: rtl/i2c_tgt10.sv
`timescale 1ns/1ps
module i2c_tgt10 #(
  parameter int STRW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  input  logic [9:0]      own_addr,
  input  logic            addr_10b,
  input  logic [1:0]      last_idx,
  input  logic            nack_last,
  input  logic [31:0]     tx_word,
  input  logic [5:0]      stretch_at,
  input  logic [STRW-1:0] stretch_len,
  output logic [31:0]     rx_word,
  output logic            rd_mode,
  output logic            addressed,
  output logic            frame_done,
  output logic            stop_seen
);
  typedef enum logic [2:0] {P_IDLE, P_ADR1, P_ADR2, P_RX, P_TX, P_IGN} phase_t;
  localparam logic [4:0] HDR10 = 5'b11110;

  phase_t          phase;
  logic [1:0]      scl_sy, sda_sy;
  logic            scl_q, sda_q;
  logic [3:0]      cnt;
  logic [1:0]      idx;
  logic [7:0]      shreg;
  logic            rw, ack_q, mack, a10_ok;
  logic [STRW-1:0] str_cnt;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_r = scl_s & ~scl_q;
  wire scl_f = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire live = (phase == P_ADR1) || (phase == P_ADR2) || (phase == P_RX) || (phase == P_TX);
  wire data_ph = (phase == P_RX) || (phase == P_TX);

  wire adr1_ack = addr_10b ? (shreg[7:1] == {HDR10, own_addr[9:8]} && (!shreg[0] || a10_ok))
                           : (shreg[7:1] == own_addr[6:0]);
  wire adr2_ack = (shreg == own_addr[7:0]);
  wire is_last  = (idx == last_idx);
  wire rx_ack   = !(is_last && nack_last);

  logic [7:0] tx_cur, tx_nxt;
  logic [5:0] dbit_no;
  assign tx_cur  = 8'(tx_word >> {idx, 3'b000});
  assign tx_nxt  = 8'(tx_word >> {idx + 2'd1, 3'b000});
  assign dbit_no = {1'b0, idx, 3'b000} + {2'b00, cnt};
  assign scl_oe  = (str_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      phase <= P_IDLE; cnt <= '0; idx <= '0; shreg <= '0;
      rw <= 1'b0; ack_q <= 1'b0; mack <= 1'b0; a10_ok <= 1'b0;
      str_cnt <= '0; sda_oe <= 1'b0; rx_word <= '0;
      rd_mode <= 1'b0; addressed <= 1'b0; frame_done <= 1'b0; stop_seen <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      frame_done <= 1'b0;
      if (str_cnt != '0) str_cnt <= str_cnt - 1'b1;

      if (stop_det) begin
        phase <= P_IDLE; stop_seen <= 1'b1; a10_ok <= 1'b0;
        sda_oe <= 1'b0; addressed <= 1'b0; rd_mode <= 1'b0;
      end else if (start_det) begin
        phase <= P_ADR1; cnt <= '0; idx <= '0; stop_seen <= 1'b0;
        sda_oe <= 1'b0; addressed <= 1'b0; rd_mode <= 1'b0;
      end else if (live && scl_r) begin
        if (cnt < 4'd8) shreg <= {shreg[6:0], sda_s};
        else if (cnt == 4'd8) mack <= ~sda_s;
        if (cnt < 4'd9) cnt <= cnt + 1'b1;
      end else if (live && scl_f && cnt != 4'd0) begin
        if (data_ph && cnt <= 4'd8 && stretch_len != '0 && dbit_no == stretch_at)
          str_cnt <= stretch_len;
        if (cnt < 4'd8) begin
          if (phase == P_TX) sda_oe <= ~tx_cur[3'd7 - cnt[2:0]];
        end else if (cnt == 4'd8) begin
          case (phase)
            P_ADR1: begin
              if (addr_10b && !shreg[0]) a10_ok <= 1'b0;
              rw <= shreg[0]; ack_q <= adr1_ack; sda_oe <= adr1_ack;
            end
            P_ADR2: begin
              ack_q <= adr2_ack; sda_oe <= adr2_ack; a10_ok <= adr2_ack;
            end
            P_RX: begin
              for (int k = 0; k < 4; k++)
                if (idx == 2'(k)) rx_word[k*8 +: 8] <= shreg;
              sda_oe <= rx_ack;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else begin
          cnt <= '0;
          sda_oe <= 1'b0;
          case (phase)
            P_ADR1: begin
              if (!ack_q) phase <= P_IGN;
              else if (addr_10b && !rw) phase <= P_ADR2;
              else if (rw) begin
                phase <= P_TX; rd_mode <= 1'b1; addressed <= 1'b1; sda_oe <= ~tx_word[7];
              end else begin
                phase <= P_RX; addressed <= 1'b1; rx_word <= '0;
              end
            end
            P_ADR2: begin
              if (ack_q) begin phase <= P_RX; addressed <= 1'b1; rx_word <= '0; end
              else phase <= P_IGN;
            end
            P_RX: begin
              if (is_last) begin phase <= P_IGN; frame_done <= 1'b1; end
              else idx <= idx + 1'b1;
            end
            default: begin
              if (mack && !is_last) begin idx <= idx + 1'b1; sda_oe <= ~tx_nxt[7]; end
              else begin phase <= P_IGN; frame_done <= 1'b1; end
            end
          endcase
        end
      end
    end
  end

  assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_stop_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (phase == P_IDLE && stop_seen));
  assert_stretch_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $past(scl_f));
  assert_done_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(scl_f));
  assert_released_when_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_IDLE || phase == P_IGN) |-> !sda_oe);
endmodule

// File: tb/test_i2c_tgt10.sv
`timescale 1ns/1ps
module test_i2c_tgt10;
  localparam int Q = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe;
  logic [9:0] own = '0;
  logic a10 = 1'b0, nackl = 1'b0;
  logic [1:0] last = '0;
  logic [31:0] txw = '0;
  logic [5:0] s_at = '0;
  logic [15:0] s_len = '0;
  logic [31:0] rx_word;
  logic rd_mode, addressed, frame_done, stop_seen;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0, fd_cnt = 0, hi_chg = 0;
  int dcount = 0, st_after = -1, st_wait = 0;
  logic oe_prev = 1'b0;

  i2c_tgt10 #(.STRW(16)) i_i2c_tgt10 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own), .addr_10b(a10),
    .last_idx(last), .nack_last(nackl), .tx_word(txw), .stretch_at(s_at),
    .stretch_len(s_len), .rx_word(rx_word), .rd_mode(rd_mode),
    .addressed(addressed), .frame_done(frame_done), .stop_seen(stop_seen));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    #2;
    if (frame_done) fd_cnt++;
    if (sda_oe !== oe_prev && scl_bus) hi_chg++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rx(input logic [31:0] d, input logic [1:0] l);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) if (k <= int'(l)) w[k*8 +: 8] = d[k*8 +: 8];
    return w;
  endfunction

  task automatic qwait(); repeat (Q) @(negedge clk); endtask
  task automatic sclhi();
    int w = 0;
    m_scl = 1'b1;
    while (!scl_bus) begin @(negedge clk); w++; end
    if (w > 2) begin st_after = dcount; st_wait = w; end
  endtask

  task automatic m_start(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait(); endtask
  task automatic m_rstart(); m_sda = 1'b1; qwait(); sclhi(); qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait(); endtask
  task automatic m_stop(); m_sda = 1'b0; qwait(); sclhi(); qwait(); m_sda = 1'b1; qwait(); qwait(); endtask
  task automatic m_bit(input logic b, output logic r);
    m_sda = b; qwait(); sclhi(); qwait(); r = sda_bus; qwait(); m_scl = 1'b0; qwait();
  endtask
  task automatic m_wr(input logic [7:0] b, input logic data, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin m_bit(b[i], r); if (data) dcount++; end
    m_bit(1'b1, r); ack = ~r;
  endtask
  task automatic m_rd(output logic [7:0] b, input logic give_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); b[i] = r; dcount++; end
    m_bit(~give_ack, r);
  endtask

  task automatic addr_phase(input logic rd);
    logic ack;
    if (!a10) begin
      m_wr({own[6:0], rd}, 1'b0, ack); chk("R3 address ack", 32'(ack), 1);
    end else begin
      m_wr({5'b11110, own[9:8], 1'b0}, 1'b0, ack); chk("R4 header ack", 32'(ack), 1);
      m_wr(own[7:0], 1'b0, ack); chk("R4 low byte ack", 32'(ack), 1);
      if (rd) begin
        m_rstart();
        m_wr({5'b11110, own[9:8], 1'b1}, 1'b0, ack); chk("R5 read header ack", 32'(ack), 1);
      end
    end
    chk("R12 addressed", 32'(addressed), 1);
    chk("R12 rd_mode", 32'(rd_mode), 32'(rd));
  endtask

  task automatic wr_frame(input int nsend, input logic [31:0] d);
    logic ack, exp;
    int fd0;
    m_start(); chk("R2 stop_seen cleared by START", 32'(stop_seen), 0);
    addr_phase(1'b0);
    dcount = 0; fd0 = fd_cnt;
    for (int k = 0; k < nsend; k++) begin
      m_wr((k < 4) ? d[k*8 +: 8] : 8'hA5, 1'b1, ack);
      exp = (k <= int'(last)) && !(k == int'(last) && nackl);
      chk("R7 data ack", 32'(ack), 32'(exp));
    end
    m_stop();
    chk("R6 rx_word", rx_word, exp_rx(d, last));
    chk("R10 frame_done count", 32'(fd_cnt - fd0), 1);
    chk("R2 stop_seen", 32'(stop_seen), 1);
    chk("R12 addressed cleared", 32'(addressed), 0);
  endtask

  task automatic rd_frame(input int nread);
    logic [7:0] b, e;
    int fd0;
    m_start();
    addr_phase(1'b1);
    dcount = 0; fd0 = fd_cnt;
    for (int k = 0; k < nread; k++) begin
      m_rd(b, k != nread - 1);
      e = (k <= int'(last)) ? txw[k*8 +: 8] : 8'hFF;
      chk("R8 read byte", 32'(b), 32'(e));
    end
    m_stop();
    chk("R10 frame_done count", 32'(fd_cnt - fd0), 1);
  endtask

  initial begin
    repeat (20000 * 9) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [31:0] keep;
    void'($urandom(32'd29));
    repeat (4) @(negedge clk);
    chk("R1 scl_oe", 32'(scl_oe), 0);
    chk("R1 sda_oe", 32'(sda_oe), 0);
    chk("R1 status", {28'd0, addressed, rd_mode, frame_done, stop_seen}, 0);
    chk("R1 rx_word", rx_word, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int it = 0; it < 2; it++) begin
      own = 10'($urandom); last = 2'($urandom); nackl = 1'($urandom); txw = $urandom;
      a10 = 1'b0; wr_frame(int'(last) + 1, $urandom); rd_frame(int'(last) + 1);
      a10 = 1'b1; wr_frame(int'(last) + 1, $urandom); rd_frame(int'(last) + 1);
      chk("R11 no hold when disabled", 32'(st_after), 32'hFFFFFFFF);
    end

    a10 = 1'b0; last = 2'd1; nackl = 1'b0;
    wr_frame(3, 32'h00C3_5A96);
    rd_frame(3);

    keep = rx_word;
    m_start(); m_wr({own[6:0] ^ 7'h01, 1'b0}, 1'b0, ack);
    chk("R3 wrong address NACK", 32'(ack), 0);
    m_wr(8'h3C, 1'b0, ack); chk("R3 ignored data NACK", 32'(ack), 0);
    m_stop(); chk("R3 rx_word untouched", rx_word, keep);

    m_wr(8'h77, 1'b0, ack); chk("R2 bits after STOP ignored", 32'(ack), 0);
    m_sda = 1'b1; qwait();

    a10 = 1'b1;
    m_start(); m_wr({5'b11110, own[9:8], 1'b1}, 1'b0, ack);
    chk("R5 read header without match NACK", 32'(ack), 0);
    m_stop();
    m_start(); m_wr({5'b11110, own[9:8], 1'b0}, 1'b0, ack);
    chk("R4 header ack", 32'(ack), 1);
    m_wr(~own[7:0], 1'b0, ack); chk("R4 wrong low byte NACK", 32'(ack), 0);
    m_rstart(); m_wr({5'b11110, own[9:8], 1'b1}, 1'b0, ack);
    chk("R5 read header after failed match NACK", 32'(ack), 0);
    m_stop();

    a10 = 1'b0; last = 2'd3; nackl = 1'b1; s_at = 6'd13; s_len = 16'd200;
    st_after = -1; wr_frame(4, 32'h1234_ABCD);
    chk("R11 stretch position", 32'(st_after), 13);
    chk("R11 stretch length", 32'((st_wait >= 200 + 3 - 2*Q - 3) && (st_wait <= 200 + 3 - 2*Q + 3)), 1);
    s_at = 6'd8; st_after = -1; txw = 32'h8001_FE7F; rd_frame(4);
    chk("R11 stretch position in read", 32'(st_after), 8);
    s_len = '0;
    chk("R9 SDA drive changed while SCL high", 32'(hi_chg), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule